// File: doc/BRIEF.md
# Packet FIFO with Commit and Abort

This block is a synchronous first-in first-out store for packets. Both its write port and its read port use a valid/ready handshake. Words move on a port only in a cycle where both valid and ready are high on that port. The storage is a flop array inside the block. The depth may be any integer of two or more, so each pointer wraps to zero after it reaches DEPTH-1.

Each port keeps two pointers: a working pointer and a committed pointer.

- **Write port.** Words written since the last write commit stay hidden from the reader. A write commit makes them visible. A write abort discards them and returns the write pointer to its committed position.
- **Read port.** The reader may read ahead without removing anything. A read abort rewinds the read pointer to the oldest word not yet released, so those words can be sent again. A read commit releases the words read so far and frees their space for the writer.

On either port, a commit or abort also covers a word transferred in the same cycle. When commit and abort are both high on one port, abort wins.

Top module: `pkt_fifo`

## Requirements
- R1: After reset, rd_valid is 0 and wr_ready is 1.
- R2: A word is taken on a port only when valid and ready are both high. Committed words come out in the order they were written, and rd_data holds while rd_ready is low.
- R3: Words written but not yet committed never make rd_valid high.
- R4: A write commit makes every pending word visible in the next cycle, including a word transferred in the commit cycle itself.
- R5: A write abort discards every uncommitted word, including a word transferred in the abort cycle. The discarded words never reach rd_data.
- R6: wr_ready is 0 exactly when DEPTH words are held, counting committed-but-unreleased words plus pending writes. A write attempted while full is ignored. Pointers wrap correctly for a depth that is not a power of two.
- R7: A read abort rewinds reading to the oldest unreleased word, including a word read in the abort cycle. That word appears again on rd_data.
- R8: A read commit frees the words read so far. wr_ready returns to 1 in the next cycle if the FIFO was full.
- R9: When commit and abort are high together on one port, abort wins. On the write port the pending words are discarded; on the read port reading rewinds and nothing is freed.
- R10: Words that were read but not committed still occupy space, so wr_ready stays 0 after a full FIFO is read out without a commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Writer offers a word |
| wr_ready | output | 1 | Space is available |
| wr_data | input | WIDTH | Word to write |
| wr_commit | input | 1 | Publish the pending written words |
| wr_abort | input | 1 | Discard the pending written words |
| rd_valid | output | 1 | A committed, unread word is available |
| rd_ready | input | 1 | Reader takes the word |
| rd_data | output | WIDTH | Word at the read pointer |
| rd_commit | input | 1 | Release the words read so far |
| rd_abort | input | 1 | Rewind to the oldest unreleased word |

## Verification
The hardest state to reach from the ports is a full FIFO whose words have all been read but not released. Reaching it needs a committed burst of exactly DEPTH words, after earlier traffic has moved the pointers away from zero so that the burst wraps, and then a full read-out with no commit. The bench builds this state in one directed task. It then shows that wr_ready stays low and a write attempt is ignored. Finally it issues a lone read commit, after which wr_ready must return high. Same-cycle combinations, such as a transfer together with an abort, or commit and abort together, are driven by separate tasks that check which words reappear.

// File: rtl/pkt_fifo_pkg.sv
package pkt_fifo_pkg;
  // Advance a pointer through 0..depth-1 with explicit wrap.
  function automatic int unsigned wrap_inc(input int unsigned p, input int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

  // Words made permanent by a commit: pending words plus one in flight.
  function automatic int unsigned settle_amt(input int unsigned pend, input bit fire);
    return pend + (fire ? 1 : 0);
  endfunction
endpackage

// File: rtl/pkt_fifo_side.sv
module pkt_fifo_side #(
  parameter int unsigned DEPTH = 6,
  localparam int unsigned PW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic          commit,
  input  logic          abort,
  output logic [PW-1:0] ptr,
  output logic [PW-1:0] cptr,
  output logic [CW-1:0] pend,
  output logic [CW-1:0] settled
);
  logic [PW-1:0] ptr_adv;

  assign ptr_adv = fire ? PW'(pkt_fifo_pkg::wrap_inc(32'(ptr), DEPTH)) : ptr;
  assign settled = (commit && !abort) ? CW'(pkt_fifo_pkg::settle_amt(32'(pend), fire)) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr  <= '0;
      cptr <= '0;
      pend <= '0;
    end else if (abort) begin
      ptr  <= cptr;
      pend <= '0;
    end else begin
      ptr <= ptr_adv;
      if (commit) begin
        cptr <= ptr_adv;
        pend <= '0;
      end else begin
        pend <= pend + CW'(fire);
      end
    end
  end
endmodule

// File: rtl/pkt_fifo_mem.sv
module pkt_fifo_mem #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 6,
  localparam int unsigned PW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [PW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [PW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/pkt_fifo.sv
module pkt_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             wr_commit,
  input  logic             wr_abort,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [WIDTH-1:0] rd_data,
  input  logic             rd_commit,
  input  logic             rd_abort
);
  localparam int unsigned PW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic          w_fire, r_fire;
  logic [PW-1:0] w_ptr, w_cptr, r_ptr, r_cptr;
  logic [CW-1:0] w_pend, r_pend, w_settled, r_settled;
  logic [CW-1:0] cnt_c, held_cnt, avail_cnt;

  assign held_cnt  = cnt_c + w_pend;
  assign avail_cnt = cnt_c - r_pend;
  assign wr_ready  = (held_cnt != CW'(DEPTH));
  assign rd_valid  = (avail_cnt != '0);
  assign w_fire    = wr_valid && wr_ready;
  assign r_fire    = rd_ready && rd_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_c <= '0;
    else        cnt_c <= cnt_c + w_settled - r_settled;
  end

  pkt_fifo_side #(.DEPTH(DEPTH)) u_wside (
    .clk(clk), .rst_n(rst_n), .fire(w_fire), .commit(wr_commit), .abort(wr_abort),
    .ptr(w_ptr), .cptr(w_cptr), .pend(w_pend), .settled(w_settled)
  );

  pkt_fifo_side #(.DEPTH(DEPTH)) u_rside (
    .clk(clk), .rst_n(rst_n), .fire(r_fire), .commit(rd_commit), .abort(rd_abort),
    .ptr(r_ptr), .cptr(r_cptr), .pend(r_pend), .settled(r_settled)
  );

  pkt_fifo_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .we(w_fire), .waddr(w_ptr), .wdata(wr_data),
    .raddr(r_ptr), .rdata(rd_data)
  );
endmodule

// File: rtl/pkt_fifo_chk.sv
module pkt_fifo_chk #(
  parameter int unsigned DEPTH = 6,
  localparam int unsigned PW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic          wr_commit,
  input logic          wr_abort,
  input logic          rd_valid,
  input logic          rd_commit,
  input logic          rd_abort,
  input logic [PW-1:0] w_ptr,
  input logic [PW-1:0] w_cptr,
  input logic [PW-1:0] r_ptr,
  input logic [PW-1:0] r_cptr,
  input logic [CW-1:0] held_cnt
);
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    held_cnt <= CW'(DEPTH));

  p_ptr_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (w_ptr < PW'(DEPTH)) && (r_ptr < PW'(DEPTH)));

  p_idle_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && wr_ready) && !wr_abort |=> $stable(w_ptr));

  p_visible_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> $past(wr_commit) || $past(rd_abort));

  p_wr_rewind_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_abort |=> w_ptr == $past(w_cptr));

  p_rd_rewind_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_abort |=> r_ptr == $past(r_cptr));

  p_space_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_ready) |-> $past(rd_commit) || $past(wr_abort));

  p_abort_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit && wr_abort |=> w_cptr == $past(w_cptr));
endmodule

bind pkt_fifo pkt_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_commit(wr_commit), .wr_abort(wr_abort), .rd_valid(rd_valid),
  .rd_commit(rd_commit), .rd_abort(rd_abort), .w_ptr(w_ptr), .w_cptr(w_cptr),
  .r_ptr(r_ptr), .r_cptr(r_cptr), .held_cnt(held_cnt)
);

// File: tb/pkt_fifo_bench.sv
module pkt_fifo_bench;
  localparam int unsigned WIDTH = 8;
  localparam int unsigned DEPTH = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0, wr_commit = 1'b0, wr_abort = 1'b0;
  logic rd_ready = 1'b0, rd_commit = 1'b0, rd_abort = 1'b0;
  logic [WIDTH-1:0] wr_data = '0;
  logic wr_ready, rd_valid;
  logic [WIDTH-1:0] rd_data;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pkt_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_pkt_fifo (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .wr_commit(wr_commit), .wr_abort(wr_abort),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .rd_commit(rd_commit), .rd_abort(rd_abort)
  );

  task automatic chk(input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    wr_valid = 0; wr_commit = 0; wr_abort = 0;
    rd_ready = 0; rd_commit = 0; rd_abort = 0;
  endtask

  task automatic wr(input int d, input bit c, input bit a);
    wr_valid = 1; wr_data = WIDTH'(d); wr_commit = c; wr_abort = a;
    tick();
  endtask

  task automatic rd(input int exp, input bit c, input bit a, input string req);
    chk({req, " rd_valid"}, int'(rd_valid), 1);
    chk({req, " rd_data"}, int'(rd_data), exp);
    rd_ready = 1; rd_commit = c; rd_abort = a;
    tick();
  endtask

  task automatic t_reset();
    chk("R1 rd_valid after reset", int'(rd_valid), 0);
    chk("R1 wr_ready after reset", int'(wr_ready), 1);
  endtask

  task automatic t_commit_visibility();
    wr(10, 0, 0); wr(11, 0, 0); wr(12, 0, 0);
    chk("R3 pending words hidden", int'(rd_valid), 0);
    wr(13, 1, 0);
    chk("R4 visible after commit", int'(rd_valid), 1);
    tick();
    chk("R2 rd_data holds without rd_ready", int'(rd_data), 10);
    rd(10, 0, 0, "R2"); rd(11, 0, 0, "R2"); rd(12, 0, 0, "R2");
    rd(13, 1, 0, "R4 same-cycle word");
    chk("R2 empty after read-out", int'(rd_valid), 0);
  endtask

  task automatic t_write_abort();
    wr(20, 0, 0); wr(21, 0, 0); wr(22, 0, 1);
    chk("R5 aborted words hidden", int'(rd_valid), 0);
    wr(23, 1, 0);
    rd(23, 1, 0, "R5 discarded words skipped");
    chk("R5 nothing left", int'(rd_valid), 0);
  endtask

  task automatic t_full_wrap();
    for (int i = 0; i < 5; i++) wr(30 + i, 0, 0);
    chk("R6 ready below depth", int'(wr_ready), 1);
    wr(35, 1, 0);
    chk("R6 full at depth", int'(wr_ready), 0);
    wr_valid = 1; wr_data = 8'd99;
    tick();
    chk("R6 still full after ignored write", int'(wr_ready), 0);
    for (int i = 0; i < 6; i++) rd(30 + i, 0, 0, "R6 order across wrap");
    chk("R10 read but unreleased still full", int'(wr_ready), 0);
    chk("R6 ignored write not stored", int'(rd_valid), 0);
    rd_commit = 1;
    tick();
    chk("R8 space after read commit", int'(wr_ready), 1);
  endtask

  task automatic t_read_abort();
    wr(40, 0, 0); wr(41, 0, 0); wr(42, 1, 0);
    rd(40, 0, 0, "R7"); rd(41, 0, 0, "R7");
    rd_abort = 1;
    tick();
    rd(40, 1, 0, "R7 rewound to oldest");
    rd(41, 0, 1, "R7");
    rd(41, 0, 0, "R7 same-cycle word returned");
    rd(42, 1, 0, "R7");
    chk("R7 empty after release", int'(rd_valid), 0);
  endtask

  task automatic t_priority();
    wr(50, 1, 1);
    chk("R9 write abort beats commit", int'(rd_valid), 0);
    wr(51, 1, 0);
    rd(51, 1, 1, "R9");
    rd(51, 1, 0, "R9 read abort beats commit");
    chk("R9 empty at end", int'(rd_valid), 0);
    chk("R9 space at end", int'(wr_ready), 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_commit_visibility();
    t_write_abort();
    t_full_wrap();
    t_read_abort();
    t_priority();
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule